// File: doc/BRIEF.md
# Bus Activity and Idle Detector

This block sits in the receive path of a differential bus transceiver. Three digitized comparator outputs come in from the analog front end: one that is high while the magnitude of the differential voltage exceeds the activity threshold, one that is high while the differential level is below the low data threshold, and one that is high while it is above the high data threshold. The block filters the magnitude input over time to decide whether the bus is active or idle. From that decision and the two data comparators it produces the receive data output.

The two confirmation times are run-time inputs given in clock cycles. Activity is declared only after the magnitude input has stayed high without a break for the activity time. Idle is declared only after it has stayed low without a break for the idle time. Once activity is declared, the receive output follows the data comparators. Once idle is declared, the receive output is forced high. The block does its work only while its enable input (normal mode) is high. While enable is low, it sits in the idle state with the receive output high.

Top module: `bus_activity_detector`

## Requirements
- R1: After reset, and one cycle after any clock edge at which `enable` is low, `bus_active` is 0 and `rxd` is 1. While `enable` is low, the comparator inputs have no effect.
- R2: While idle and enabled, `bus_active` rises at the clock edge that completes `act_time` consecutive cycles with `above_thr` high. It is observed high in the cycle after that edge.
- R3: Any cycle with `above_thr` low while idle restarts the activity count from zero.
- R4: While active, any cycle with `above_thr` high restarts the idle count from zero. `bus_active` falls at the edge that completes `idle_time` consecutive cycles with `above_thr` low.
- R5: When idle is declared, `rxd` is driven to 1. `rxd` stays 1 for as long as the block is idle.
- R6: While active, `data_lo` high sets `rxd` to 0 at the next edge. `data_lo` takes priority over `data_hi`.
- R7: While active, `data_hi` high with `data_lo` low sets `rxd` to 1 at the next edge.
- R8: While active, when both data comparators are low, `rxd` keeps its previous value.
- R9: An `act_time` or `idle_time` of 1 means a single qualifying cycle is enough. A value of 0 behaves like 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Normal mode; detection runs only while high |
| above_thr | input | 1 | Differential magnitude above the activity threshold |
| data_lo | input | 1 | Differential level below the low data threshold |
| data_hi | input | 1 | Differential level above the high data threshold |
| act_time | input | CNT_W | Activity confirmation time in cycles |
| idle_time | input | CNT_W | Idle confirmation time in cycles |
| rxd | output | 1 | Receive data |
| bus_active | output | 1 | Declared bus state (1 = active) |

## Verification
The detector is driven with magnitude bursts that are one cycle short of the activity time and then broken. These show that the count restarts instead of accumulating. Idle gaps cut short by a single active cycle separate a restarting idle count from a running one. While the bus is active, the data comparators are stepped through low, high, neither and both. This tells apart following the data, holding the previous value, and giving priority to the low comparator. Further cases check that stimulus arriving before activity is declared, or while the block is disabled, leaves `rxd` high. A time of 1 checks that a single qualifying cycle is enough.

// File: rtl/bus_activity_detector.sv
module bus_activity_detector #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             above_thr,
  input  logic             data_lo,
  input  logic             data_hi,
  input  logic [CNT_W-1:0] act_time,
  input  logic [CNT_W-1:0] idle_time,
  output logic             rxd,
  output logic             bus_active
);

  logic [CNT_W-1:0] run_cnt;
  logic [CNT_W:0]   run_next;
  logic             qualify;
  logic             reached;

  assign run_next = {1'b0, run_cnt} + 1'b1;
  assign qualify  = bus_active ? !above_thr : above_thr;
  assign reached  = bus_active ? (run_next >= {1'b0, idle_time})
                               : (run_next >= {1'b0, act_time});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt    <= '0;
      bus_active <= 1'b0;
      rxd        <= 1'b1;
    end else if (!enable) begin
      run_cnt    <= '0;
      bus_active <= 1'b0;
      rxd        <= 1'b1;
    end else begin
      if (!qualify) begin
        run_cnt <= '0;
      end else if (reached) begin
        run_cnt    <= '0;
        bus_active <= !bus_active;
      end else begin
        run_cnt <= run_next[CNT_W-1:0];
      end

      if (bus_active && qualify && reached) begin
        rxd <= 1'b1;
      end else if (bus_active) begin
        if (data_lo)      rxd <= 1'b0;
        else if (data_hi) rxd <= 1'b1;
      end else begin
        rxd <= 1'b1;
      end
    end
  end

endmodule

module bus_activity_detector_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic above_thr,
  input logic data_lo,
  input logic data_hi,
  input logic rxd,
  input logic bus_active
);

  // R1
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!bus_active && rxd));

  // R2
  rise_needs_mag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_active) |-> $past(above_thr) && $past(enable));

  // R5
  idle_rxd_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_active |-> rxd);

  // R6
  data_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && bus_active && above_thr && data_lo) |=> !rxd);

  // R7
  data_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && bus_active && above_thr && data_hi && !data_lo) |=> rxd);

  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && bus_active && above_thr && !data_hi && !data_lo) |=> $stable(rxd));

endmodule

bind bus_activity_detector bus_activity_detector_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .above_thr(above_thr),
  .data_lo(data_lo), .data_hi(data_hi), .rxd(rxd), .bus_active(bus_active)
);

// File: tb/sim_bus_activity_detector.sv
`timescale 1ns/1ps
module sim_bus_activity_detector;
  localparam int CW = 16;

  logic clk = 0, rst_n = 0, enable = 0, above_thr = 0, data_lo = 0, data_hi = 0;
  logic [CW-1:0] act_time = 3, idle_time = 2;
  logic rxd, bus_active;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  bus_activity_detector #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .above_thr(above_thr),
    .data_lo(data_lo), .data_hi(data_hi), .act_time(act_time),
    .idle_time(idle_time), .rxd(rxd), .bus_active(bus_active));

  // {enable, above_thr, data_lo, data_hi, exp_active, exp_rxd}; act_time=3, idle_time=2
  localparam int NV = 20;
  localparam logic [5:0] VEC [NV] = '{
    6'b110001, 6'b110001, 6'b111011, 6'b111010, 6'b110010,
    6'b110111, 6'b111010, 6'b100010, 6'b110010, 6'b100010,
    6'b100001, 6'b111001, 6'b100001, 6'b110001, 6'b110001,
    6'b110011, 6'b111010, 6'b000001, 6'b011001, 6'b110001};
  localparam string TAG [NV] = '{
    "R3", "R3", "R2", "R6", "R8", "R7", "R6", "R4", "R4", "R4",
    "R5", "R5", "R3", "R3", "R3", "R2", "R6", "R1", "R1", "R2"};

  task automatic check(input string req, input logic act, input logic rx);
    checks++;
    if (bus_active !== act || rxd !== rx) begin
      failures++;
      $display("FAIL %s: bus_active=%b rxd=%b expected bus_active=%b rxd=%b",
               req, bus_active, rxd, act, rx);
    end
  endtask

  task automatic step(input logic e, input logic a, input logic l, input logic h);
    enable = e; above_thr = a; data_lo = l; data_hi = h;
    @(posedge clk); #5;
  endtask

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1", 1'b0, 1'b1);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2]);
      check(TAG[i], VEC[i][1], VEC[i][0]);
      @(negedge clk);
    end

    // R9: single-cycle times
    act_time = 1; idle_time = 1;
    step(1, 0, 0, 0); check("R9", 1'b0, 1'b1); @(negedge clk);
    step(1, 1, 1, 0); check("R9", 1'b1, 1'b1); @(negedge clk);
    // R6: both comparators high, low one wins
    step(1, 1, 1, 1); check("R6", 1'b1, 1'b0); @(negedge clk);
    step(1, 0, 0, 0); check("R9", 1'b0, 1'b1); @(negedge clk);
    // R9: zero behaves like one
    act_time = 0; idle_time = 0;
    step(1, 1, 0, 0); check("R9", 1'b1, 1'b1); @(negedge clk);
    step(1, 1, 1, 0); check("R6", 1'b1, 1'b0); @(negedge clk);
    // R1: reset while active
    rst_n = 0; #1; check("R1", 1'b0, 1'b1);
    @(negedge clk); rst_n = 1;
    // R2: longer activity time
    act_time = 5; idle_time = 4;
    for (int k = 0; k < 4; k++) begin
      step(1, 1, 1, 0); check("R2", 1'b0, 1'b1); @(negedge clk);
    end
    step(1, 1, 1, 0); check("R2", 1'b1, 1'b1); @(negedge clk);
    step(1, 1, 1, 0); check("R6", 1'b1, 1'b0); @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      step(1, 0, 0, 0); check("R4", 1'b1, 1'b0); @(negedge clk);
    end
    step(1, 0, 0, 0); check("R5", 1'b0, 1'b1); @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule